// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up one GPIO input before the pin status and edge detection logic see it. The raw pad level is first brought into the core clock domain through a two-stage synchronizer. It then passes through a filter whose hold time is counted in ticks of a slow real-time clock. The tick arrives as a one-cycle enable on `rtcTick`, synchronous to `clk`. The filtered level appears on `pinFiltered`.

A configuration register supplies five fields: a 4-bit count, a unit select bit, a range select bit and a 2-bit filter type. The two select bits pick how many RTC ticks make up one time unit. The filter time is the count multiplied by that unit. The filter type chooses one of four behaviours:

- Bypass: no filtering is applied.
- Remove-glitch: both edges are filtered.
- Pass-low: short low pulses reach the output unfiltered.
- Pass-high: short high pulses reach the output unfiltered.

Whenever software writes the debounce fields, it pulses `cfgWrite`. This restarts the filter from the current synchronized level.

Top module: `gpio_debounce_filter`

## Requirements
- R1: While reset is asserted, and on the first clock after reset is released, `pinFiltered` is 0.
- R2: With filter type 2'b00 (bypass), `pinFiltered` follows `pinRaw` with a latency of three clock edges: two synchronizer stages, then the output register. No tick is needed.
- R3: The unit length in RTC ticks is selected by {cfgRangeSel, cfgUnitSel}:
  - 2'b00 gives 2 ticks.
  - 2'b01 gives 8 ticks.
  - 2'b10 gives 512 ticks.
  - 2'b11 gives 2048 ticks.
- R4: When the synchronized level differs from the output and the transition is qualified, the output takes the new level at the edge on which the cfgCount × unit-th `rtcTick` is seen. Only ticks seen while the difference persists are counted.
- R5: With filter type 2'b11 (remove-glitch), both rising and falling transitions are qualified. If the synchronized level returns to the output level before the time expires, the count restarts from zero.
- R6: With filter type 2'b01 (pass-low), the following apply:
  - A falling transition reaches the output with the R2 latency.
  - Only rising transitions wait for the filter time.
- R7: With filter type 2'b10 (pass-high), the following apply:
  - A rising transition reaches the output with the R2 latency.
  - Only falling transitions wait for the filter time.
- R8: A cfgCount of 0 with filtering enabled behaves as a count of 1.
- R9: A cycle with `cfgWrite` high has two effects:
  - It discards any partial count.
  - At that edge, it loads the output with the current synchronized level.
- R10: Cycles without `rtcTick` do not advance the filter. In a filtering mode, the output changes only on an edge where `rtcTick` or `cfgWrite` is high, or on a non-qualified transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rtcTick | input | 1 | One-cycle enable marking each slow RTC clock period |
| pinRaw | input | 1 | Asynchronous raw pad level |
| cfgCount | input | 4 | Filter length in units (0 acts as 1) |
| cfgUnitSel | input | 1 | Low bit of the unit select |
| cfgRangeSel | input | 1 | High bit of the unit select |
| cfgMode | input | 2 | Filter type: 00 bypass, 01 pass-low, 10 pass-high, 11 remove-glitch |
| cfgWrite | input | 1 | Pulse on any write of the debounce fields |
| pinFiltered | output | 1 | Filtered pin level |

## Verification
The filter is driven with several kinds of input:

- Clean single transitions, with all four unit selects and several counts. These separate the unit lengths from each other and expose off-by-one errors in the count-times-unit product.
- Short bounces that return before the time expires. These distinguish a timer that restarts on a bounce from one that keeps accumulating.
- Both edge polarities under the pass-low and pass-high types. These show which direction is qualified and which passes straight through.
- A count of zero.
- A configuration write in the middle of a pending transition.
- A sparse tick pattern. This shows that only tick cycles advance the filter.

A behavioural model computes the expected level on every clock. Directed checks pin down the exact edge on which each transition appears.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

  typedef enum logic [1:0] {
    DB_BYPASS    = 2'b00,
    DB_PASS_LOW  = 2'b01,
    DB_PASS_HIGH = 2'b10,
    DB_REMOVE    = 2'b11
  } dbMode_e;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic restart;   // configuration written: reload output, clear count
    logic unitTick;  // one full unit of RTC ticks has elapsed while pending
  } dbStrobe_t;

endpackage

// File: rtl/debounce_control.sv
module debounce_control
  import debounce_pkg::*;
#(
  parameter int UNIT_TICKS0 = 2,
  parameter int UNIT_TICKS1 = 8,
  parameter int UNIT_TICKS2 = 512,
  parameter int UNIT_TICKS3 = 2048
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rtcTick,
  input  logic      cfgUnitSel,
  input  logic      cfgRangeSel,
  input  logic      cfgWrite,
  input  logic      pending,
  output dbStrobe_t strobe
);

  localparam int MAX01  = (UNIT_TICKS0 > UNIT_TICKS1) ? UNIT_TICKS0 : UNIT_TICKS1;
  localparam int MAX23  = (UNIT_TICKS2 > UNIT_TICKS3) ? UNIT_TICKS2 : UNIT_TICKS3;
  localparam int MAXU   = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int PRE_W  = (MAXU > 2) ? $clog2(MAXU) : 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] unitLast;
  logic             unitDone;

  always_comb begin
    case ({cfgRangeSel, cfgUnitSel})
      2'b00:   unitLast = PRE_W'(UNIT_TICKS0 - 1);
      2'b01:   unitLast = PRE_W'(UNIT_TICKS1 - 1);
      2'b10:   unitLast = PRE_W'(UNIT_TICKS2 - 1);
      default: unitLast = PRE_W'(UNIT_TICKS3 - 1);
    endcase
  end

  assign unitDone = (preCnt == unitLast);

  // Prescaler runs only while a qualified transition is pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (cfgWrite || !pending) begin
      preCnt <= '0;
    end else if (rtcTick) begin
      preCnt <= unitDone ? '0 : preCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.restart  = cfgWrite;
    strobe.unitTick = pending && !cfgWrite && rtcTick && unitDone;
  end

endmodule

// File: rtl/debounce_datapath.sv
module debounce_datapath
  import debounce_pkg::*;
#(
  parameter int COUNT_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pinRaw,
  input  logic [COUNT_W-1:0] cfgCount,
  input  logic [1:0]         cfgMode,
  input  dbStrobe_t          strobe,
  output logic               syncLvl,
  output logic               pending,
  output logic               pinFiltered
);

  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   filtOut;
  logic [COUNT_W-1:0]     dbCnt;
  logic [COUNT_W-1:0]     effCount;
  logic                   mismatch;
  logic                   qualifies;
  logic                   expired;
  dbMode_e                mode;

  // Synchronizer chain, length chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '0;
        else       syncPipe <= pinRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '0;
        else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], pinRaw};
      end
    end
  endgenerate

  assign syncLvl  = syncPipe[SYNC_STAGES-1];
  assign mode     = dbMode_e'(cfgMode);
  assign mismatch = (syncLvl != filtOut);
  assign effCount = (cfgCount == '0) ? COUNT_W'(1) : cfgCount;
  assign expired  = ({1'b0, dbCnt} + 1'b1) >= {1'b0, effCount};

  always_comb begin
    case (mode)
      DB_REMOVE:    qualifies = 1'b1;
      DB_PASS_LOW:  qualifies = syncLvl;   // only rises are timed
      DB_PASS_HIGH: qualifies = !syncLvl;  // only falls are timed
      default:      qualifies = 1'b0;
    endcase
  end

  assign pending = mismatch && qualifies;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtOut <= 1'b0;
      dbCnt   <= '0;
    end else if (strobe.restart) begin
      filtOut <= syncLvl;
      dbCnt   <= '0;
    end else if (mismatch && !qualifies) begin
      filtOut <= syncLvl;
      dbCnt   <= '0;
    end else if (!mismatch) begin
      dbCnt   <= '0;
    end else if (strobe.unitTick) begin
      if (expired) begin
        filtOut <= syncLvl;
        dbCnt   <= '0;
      end else begin
        dbCnt   <= dbCnt + 1'b1;
      end
    end
  end

  assign pinFiltered = filtOut;

endmodule

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter
  import debounce_pkg::*;
#(
  parameter int COUNT_W     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int UNIT_TICKS0 = 2,
  parameter int UNIT_TICKS1 = 8,
  parameter int UNIT_TICKS2 = 512,
  parameter int UNIT_TICKS3 = 2048
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rtcTick,
  input  logic               pinRaw,
  input  logic [COUNT_W-1:0] cfgCount,
  input  logic               cfgUnitSel,
  input  logic               cfgRangeSel,
  input  logic [1:0]         cfgMode,
  input  logic               cfgWrite,
  output logic               pinFiltered
);

  dbStrobe_t strobe;
  logic      pending;
  logic      syncLvl;

  debounce_control #(
    .UNIT_TICKS0(UNIT_TICKS0),
    .UNIT_TICKS1(UNIT_TICKS1),
    .UNIT_TICKS2(UNIT_TICKS2),
    .UNIT_TICKS3(UNIT_TICKS3)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .rtcTick    (rtcTick),
    .cfgUnitSel (cfgUnitSel),
    .cfgRangeSel(cfgRangeSel),
    .cfgWrite   (cfgWrite),
    .pending    (pending),
    .strobe     (strobe)
  );

  debounce_datapath #(
    .COUNT_W    (COUNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pinRaw     (pinRaw),
    .cfgCount   (cfgCount),
    .cfgMode    (cfgMode),
    .strobe     (strobe),
    .syncLvl    (syncLvl),
    .pending    (pending),
    .pinFiltered(pinFiltered)
  );

endmodule

// File: rtl/debounce_checker.sv
module debounce_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rtcTick,
  input logic [1:0] cfgMode,
  input logic       cfgWrite,
  input logic       syncLvl,
  input logic       pinFiltered
);

  // R1: output is low on the first edge after reset release
  a_r1_reset_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !pinFiltered);

  // R2: bypass type tracks the synchronized level one edge later
  a_r2_bypass_follow: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b00) |=> (pinFiltered == $past(syncLvl)));

  // R9: a configuration write reloads the output from the synchronizer
  a_r9_write_reload: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (pinFiltered == $past(syncLvl)));

  // R5 / R10: remove-glitch output moves only on tick or write cycles
  a_r5_remove_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b11 && !cfgWrite && !rtcTick) |=> $stable(pinFiltered));

  // R6: pass-low type never raises the output without a tick
  a_r6_low_rise_timed: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b01 && !cfgWrite && !rtcTick && !pinFiltered) |=> !pinFiltered);

  // R7: pass-high type never lowers the output without a tick
  a_r7_high_fall_timed: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b10 && !cfgWrite && !rtcTick && pinFiltered) |=> pinFiltered);

endmodule

bind gpio_debounce_filter debounce_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rtcTick    (rtcTick),
  .cfgMode    (cfgMode),
  .cfgWrite   (cfgWrite),
  .syncLvl    (syncLvl),
  .pinFiltered(pinFiltered)
);

// File: tb/tb_gpio_debounce_filter.sv
`timescale 1ns/1ps
module tb_gpio_debounce_filter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rtcTick = 1'b0;
  logic       pinRaw = 1'b0;
  logic [3:0] cfgCount = 4'd1;
  logic       cfgUnitSel = 1'b0;
  logic       cfgRangeSel = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic       cfgWrite = 1'b0;
  logic       pinFiltered;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  int    tickDiv = 1;
  int    divCnt = 0;
  bit    done = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  gpio_debounce_filter dut (
    .clk(clk), .rstN(rstN), .rtcTick(rtcTick), .pinRaw(pinRaw),
    .cfgCount(cfgCount), .cfgUnitSel(cfgUnitSel), .cfgRangeSel(cfgRangeSel),
    .cfgMode(cfgMode), .cfgWrite(cfgWrite), .pinFiltered(pinFiltered)
  );

  // RTC tick generator: one pulse every tickDiv clocks
  always @(negedge clk) begin
    if (divCnt >= tickDiv - 1) begin
      divCnt  <= 0;
      rtcTick <= 1'b1;
    end else begin
      divCnt  <= divCnt + 1;
      rtcTick <= 1'b0;
    end
  end

  // Behavioural reference model
  bit rawHist[$];
  bit expOut = 0;
  int held = 0;

  function automatic int unitLen(bit rng, bit unt);
    case ({rng, unt})
      2'b00:   return 2;
      2'b01:   return 8;
      2'b10:   return 512;
      default: return 2048;
    endcase
  endfunction

  always @(posedge clk) begin
    bit lvl;
    bit timed;
    int need;
    if (!rstN) begin
      rawHist = {1'b0, 1'b0};
      expOut  = 0;
      held    = 0;
    end else begin
      lvl = rawHist[rawHist.size() - 2];
      case (cfgMode)
        2'b11:   timed = 1;
        2'b01:   timed = lvl;
        2'b10:   timed = !lvl;
        default: timed = 0;
      endcase
      need = ((cfgCount == 0) ? 1 : int'(cfgCount)) * unitLen(cfgRangeSel, cfgUnitSel);
      if (cfgWrite) begin
        expOut = lvl; held = 0;
      end else if (lvl == expOut) begin
        held = 0;
      end else if (!timed) begin
        expOut = lvl; held = 0;
      end else if (rtcTick) begin
        held++;
        if (held >= need) begin
          expOut = lvl; held = 0;
        end
      end
      rawHist.push_back(pinRaw);
      if (rawHist.size() > 4) void'(rawHist.pop_front());
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (pinFiltered !== expOut) begin
        errors++;
        $display("FAIL %s model compare t=%0t actual=%0b expected=%0b",
                 curReq, $time, pinFiltered, expOut);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic expectLvl(string req, bit exp);
    checks++;
    if (pinFiltered !== exp) begin
      errors++;
      $display("FAIL %s directed t=%0t actual=%0b expected=%0b", req, $time, pinFiltered, exp);
    end
  endtask

  task automatic writeCfg(int cnt, bit rng, bit unt, bit [1:0] md);
    @(negedge clk);
    cfgCount = 4'(cnt); cfgRangeSel = rng; cfgUnitSel = unt; cfgMode = md;
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a new raw level; expect the change exactly after n ticks (tick every clock)
  task automatic timedEdge(string req, bit newVal, int n);
    @(negedge clk);
    pinRaw = newVal;
    repeat (n + 1) @(negedge clk);
    expectLvl(req, !newVal);
    @(negedge clk);
    expectLvl(req, newVal);
  endtask

  initial begin
    // R1: reset
    settle(4);
    expectLvl("R1", 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectLvl("R1", 1'b0);

    // R2: bypass latency
    curReq = "R2";
    writeCfg(1, 0, 0, 2'b00);
    timedEdge("R2", 1'b1, 1);
    timedEdge("R2", 1'b0, 1);

    // R3 / R4: remove-glitch, each unit select
    curReq = "R3";
    writeCfg(3, 0, 0, 2'b11);
    timedEdge("R3 unit2 x3", 1'b1, 6);
    timedEdge("R4 unit2 x3 fall", 1'b0, 6);
    writeCfg(2, 0, 1, 2'b11);
    timedEdge("R3 unit8 x2", 1'b1, 16);
    timedEdge("R4 unit8 x2 fall", 1'b0, 16);
    curReq = "R4";
    writeCfg(1, 1, 0, 2'b11);
    timedEdge("R3 unit512", 1'b1, 512);
    writeCfg(1, 1, 1, 2'b11);
    timedEdge("R3 unit2048", 1'b0, 2048);

    // R5: bounce restarts the timer
    curReq = "R5";
    writeCfg(4, 0, 0, 2'b11);
    @(negedge clk); pinRaw = 1'b1;
    settle(6);
    pinRaw = 1'b0;
    settle(8);
    expectLvl("R5 bounce rejected", 1'b0);
    timedEdge("R5 full hold", 1'b1, 8);
    @(negedge clk); pinRaw = 1'b0;
    settle(7);
    pinRaw = 1'b1;
    settle(12);
    expectLvl("R5 low bounce rejected", 1'b1);

    // R6: pass-low
    curReq = "R6";
    writeCfg(2, 0, 0, 2'b01);
    timedEdge("R6 fall passes", 1'b0, 1);
    timedEdge("R6 rise timed", 1'b1, 4);
    @(negedge clk); pinRaw = 1'b0;
    @(negedge clk); pinRaw = 1'b1;
    settle(3);
    expectLvl("R6 low glitch passes", 1'b0);
    settle(6);
    expectLvl("R6 recovers after hold", 1'b1);

    // R7: pass-high
    curReq = "R7";
    writeCfg(2, 0, 0, 2'b10);
    timedEdge("R7 fall timed", 1'b0, 4);
    timedEdge("R7 rise passes", 1'b1, 1);
    timedEdge("R7 fall timed again", 1'b0, 4);

    // R8: count zero behaves as one
    curReq = "R8";
    writeCfg(0, 0, 0, 2'b11);
    timedEdge("R8 count0", 1'b1, 2);
    timedEdge("R8 count0 fall", 1'b0, 2);

    // R9: configuration write during a pending transition
    curReq = "R9";
    writeCfg(15, 1, 1, 2'b11);
    @(negedge clk); pinRaw = 1'b1;
    settle(5);
    expectLvl("R9 still pending", 1'b0);
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
    expectLvl("R9 reload on write", 1'b1);
    settle(3);

    // R10: sparse ticks
    curReq = "R10";
    tickDiv = 3;
    writeCfg(2, 0, 0, 2'b11);
    @(negedge clk); pinRaw = 1'b0;
    settle(6);
    expectLvl("R10 sparse ticks not yet", 1'b1);
    settle(20);
    expectLvl("R10 sparse ticks done", 1'b0);
    tickDiv = 1;
    settle(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule